// File: doc/BRIEF.md
# Codec Serial Port Framing Engine

This block is the device side of a synchronous serial link between a voiceband codec and a host processor. It builds the serial clock from the master clock by dividing it by five, with three master cycles low and two high in every period. Once both operating enables are set, it emits one output frame sync every sample period and shifts a 16-bit sample out, most significant bit first. The first frame after a wake-up comes only after a fixed start-up delay.

In the other direction, the host marks each incoming word with a one-serial-cycle frame sync, together with a data/control flag. The block samples the 16 following bits on falling serial-clock edges and hands the finished word to a command handler with its tag. The latest data word is held. At every outgoing frame it is presented again as the playback sample, so if the host sends nothing in a period the previous word is used. A low chip select silences the serial outputs and makes the block deaf to the host, and a word cut by that is discarded.

Top module: `codec_serial_engine`

## Requirements
- R1: While chip select is high, the serial clock output repeats a 5-master-cycle pattern: low for 3 cycles, then high for 2.
- R2: While chip select is low, serial clock, data out and frame sync out are 0 and drive_en_o is 0. Host inputs are ignored, and a word interrupted by chip select going low is never delivered.
- R3: A host word is the 16 bits sampled on the 16 falling serial-clock edges that follow the falling edge at which the host frame sync was seen high, most significant bit first. rx_stb_o pulses for one master cycle right after the last falling edge, with the word on rx_word_o.
- R4: The data/control flag is sampled with the host frame sync and appears on rx_is_data_o with the word (1 = data, 0 = control).
- R5: A host frame sync seen during bits 1 to 15 of a word is ignored. One seen at the last-bit falling edge starts the next word at once, with its own flag taken at that edge.
- R6: Output frame syncs are 325 serial-clock periods apart. Each is high for exactly one serial period, and it changes just after a rising serial-clock edge.
- R7: The 16 serial periods after the output frame sync carry tx_sample_i, most significant bit first, as captured at the frame sync. A change of tx_sample_i during the word does not affect it.
- R8: No output frame sync and no output data occur unless both run_dig_i and run_ana_i are 1.
- R9: After both enables become 1, the first output frame sync rises on the 410th rising serial-clock edge.
- R10: One master cycle after each output frame sync rises, play_stb_o pulses and play_word_o shows the most recent host data word. Control words leave it unchanged, and with no new data word it repeats the previous one.
- R11: Reset clears the received word, the playback word and the serial outputs to 0, holds the serial clock low, and does not force drive_en_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| cs_i | input | 1 | Chip select, active high |
| host_fs_i | input | 1 | Host frame sync for incoming words |
| host_sd_i | input | 1 | Host serial data |
| host_dc_i | input | 1 | Data (1) or control (0) flag for the word |
| run_dig_i | input | 1 | Digital section enable (1 = operating) |
| run_ana_i | input | 1 | Analog section enable (1 = operating) |
| tx_sample_i | input | 16 | Sample to send in the next output frame |
| sclk_o | output | 1 | Serial clock |
| sd_o | output | 1 | Serial data to host |
| fs_o | output | 1 | Output frame sync |
| drive_en_o | output | 1 | Pad drive enable for the three serial outputs |
| rx_word_o | output | 16 | Last received host word |
| rx_is_data_o | output | 1 | Tag of rx_word_o |
| rx_stb_o | output | 1 | One-cycle pulse when a host word completes |
| play_word_o | output | 16 | Held data word presented per frame |
| play_stb_o | output | 1 | One-cycle pulse per frame for play_word_o |

## Verification
A wrong divider phase shows on sclk_o within five master cycles as a duty pattern other than two high and three low. A bit counter off by one shows within one received word as a shifted rx_word_o or a missing strobe. A back-to-back frame sync that is ignored, or one honoured mid-word, corrupts the very next delivered word. Errors in the frame or wake counters show as frame sync spacing other than 325 serial periods, or a first frame other than the 410th rising edge. The bench measures these counts directly on the pins, within one frame or one wake-up.

// File: rtl/csp_pkg.sv
package csp_pkg;
    typedef enum logic [1:0] {
        TX_OFF  = 2'd0,
        TX_WAKE = 2'd1,
        TX_RUN  = 2'd2
    } tx_mode_e;
endpackage

// File: rtl/csp_clkgen.sv
module csp_clkgen #(
    parameter int DIV = 5,
    parameter int LOW = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int PW = $clog2(DIV);

    typedef struct packed {
        logic [PW-1:0] ph;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (q.ph == PW'(DIV - 1)) d.ph = '0;
        else                      d.ph = q.ph + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk      = (q.ph >= PW'(LOW));
    assign rise_tick = (q.ph == PW'(LOW - 1));
    assign fall_tick = (q.ph == PW'(DIV - 1));

    generate
        if (DIV == 5 && LOW == 3) begin : g_chk
            // R1
            sclk_low3_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(sclk) |=> !sclk ##1 !sclk ##1 sclk);
            // R1
            sclk_high2_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(sclk) |=> sclk ##1 !sclk);
        end
    endgenerate
endmodule

// File: rtl/csp_rx.sv
module csp_rx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs,
    input  logic         smp_tick,
    input  logic         frm,
    input  logic         sdi,
    input  logic         dc,
    output logic [W-1:0] word,
    output logic         is_data,
    output logic         stb
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic          act;
        logic          tag;
        logic [CW-1:0] cnt;
        logic [W-1:0]  sh;
        logic [W-1:0]  word;
        logic          is_data;
        logic          stb;
    } st_t;

    st_t q, d;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (!cs) begin
            d.act = 1'b0;
        end else if (smp_tick) begin
            if (q.act) begin
                d.sh = {q.sh[W-2:0], sdi};
                if (q.cnt == CW'(W - 1)) begin
                    d.word    = {q.sh[W-2:0], sdi};
                    d.is_data = q.tag;
                    d.stb     = 1'b1;
                    d.act     = frm;
                    d.tag     = dc;
                    d.cnt     = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else if (frm) begin
                d.act = 1'b1;
                d.tag = dc;
                d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word    = q.word;
    assign is_data = q.is_data;
    assign stb     = q.stb;

    // R2
    cs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !q.stb);
    // R3
    stb_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |-> $past(smp_tick));
endmodule

// File: rtl/csp_tx.sv
module csp_tx
    import csp_pkg::*;
#(
    parameter int W     = 16,
    parameter int FRAME = 325,
    parameter int WAKE  = 410
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_tick,
    input  logic         en,
    input  logic [W-1:0] sample,
    output logic         sofs,
    output logic         sdo,
    output logic         fire
);
    localparam int FCW = $clog2(FRAME);
    localparam int WCW = $clog2(WAKE);

    typedef struct packed {
        tx_mode_e       mode;
        logic [WCW-1:0] wcnt;
        logic [FCW-1:0] fcnt;
        logic [W-1:0]   sh;
        logic           sofs;
        logic           sdo;
        logic           fire;
    } st_t;

    st_t  q, d;
    logic start;

    always_comb begin
        d      = q;
        d.fire = 1'b0;
        start  = 1'b0;
        if (!en) begin
            d.mode = TX_OFF;
            d.wcnt = '0;
            d.fcnt = '0;
            d.sofs = 1'b0;
            d.sdo  = 1'b0;
        end else begin
            case (q.mode)
                TX_OFF: begin
                    d.mode = TX_WAKE;
                    d.wcnt = '0;
                end
                TX_WAKE: begin
                    if (rise_tick) begin
                        if (q.wcnt == WCW'(WAKE - 1)) start  = 1'b1;
                        else                          d.wcnt = q.wcnt + 1'b1;
                    end
                end
                default: begin
                    if (rise_tick) begin
                        if (q.fcnt == FCW'(FRAME - 1)) begin
                            start = 1'b1;
                        end else begin
                            d.fcnt = q.fcnt + 1'b1;
                            d.sofs = 1'b0;
                            if (q.fcnt < FCW'(W)) begin
                                d.sdo = q.sh[W-1];
                                d.sh  = q.sh << 1;
                            end else begin
                                d.sdo = 1'b0;
                            end
                        end
                    end
                end
            endcase
            if (start) begin
                d.mode = TX_RUN;
                d.fcnt = '0;
                d.sofs = 1'b1;
                d.sdo  = 1'b0;
                d.sh   = sample;
                d.fire = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= TX_OFF;
        end else begin
            q <= d;
        end
    end

    assign sofs = q.sofs;
    assign sdo  = q.sdo;
    assign fire = q.fire;

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sofs && !sdo));
    // R6
    sync_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sofs |-> !sdo);
endmodule

// File: rtl/codec_serial_engine.sv
module codec_serial_engine #(
    parameter int DATA_W      = 16,
    parameter int CLK_DIV     = 5,
    parameter int SCLK_LOW    = 3,
    parameter int FRAME_SCLKS = 325,
    parameter int WAKE_SCLKS  = 410
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              host_fs_i,
    input  logic              host_sd_i,
    input  logic              host_dc_i,
    input  logic              run_dig_i,
    input  logic              run_ana_i,
    input  logic [DATA_W-1:0] tx_sample_i,
    output logic              sclk_o,
    output logic              sd_o,
    output logic              fs_o,
    output logic              drive_en_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              rx_is_data_o,
    output logic              rx_stb_o,
    output logic [DATA_W-1:0] play_word_o,
    output logic              play_stb_o
);
    logic sclk_int, rise_tick, fall_tick;
    logic tx_sofs, tx_sdo, tx_fire;
    logic tx_en;

    assign tx_en = run_dig_i & run_ana_i;

    csp_clkgen #(.DIV(CLK_DIV), .LOW(SCLK_LOW)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk_int),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    csp_rx #(.W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs_i),
        .smp_tick (fall_tick),
        .frm      (host_fs_i),
        .sdi      (host_sd_i),
        .dc       (host_dc_i),
        .word     (rx_word_o),
        .is_data  (rx_is_data_o),
        .stb      (rx_stb_o)
    );

    csp_tx #(.W(DATA_W), .FRAME(FRAME_SCLKS), .WAKE(WAKE_SCLKS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_tick (rise_tick),
        .en        (tx_en),
        .sample    (tx_sample_i),
        .sofs      (tx_sofs),
        .sdo       (tx_sdo),
        .fire      (tx_fire)
    );

    typedef struct packed {
        logic [DATA_W-1:0] held;
        logic [DATA_W-1:0] play;
        logic              pstb;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        d.pstb = 1'b0;
        if (rx_stb_o && rx_is_data_o) d.held = rx_word_o;
        if (tx_fire) begin
            d.play = d.held;
            d.pstb = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign play_word_o = q.play;
    assign play_stb_o  = q.pstb;
    assign sclk_o      = cs_i & sclk_int;
    assign sd_o        = cs_i & tx_sdo;
    assign fs_o        = cs_i & tx_sofs;
    assign drive_en_o  = cs_i;

    // R10
    play_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        play_stb_o |-> $past(tx_fire));
    // R8
    play_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !$past(tx_en)) |-> !play_stb_o);
endmodule

// File: tb/sim_codec_serial_engine.sv
`timescale 1ns/1ps
module sim_codec_serial_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b1, fs = 1'b0, sd = 1'b0, dc = 1'b0;
    logic        run_d = 1'b0, run_a = 1'b0;
    logic [15:0] txs = 16'h0;
    logic        sclk_o, sd_o, fs_o, drive_en_o, rx_is_data_o, rx_stb_o, play_stb_o;
    logic [15:0] rx_word_o, play_word_o;

    int total = 0, fails = 0;
    int stb_cnt = 0, fs_cnt = 0;
    logic        got_stb, got_dat;
    logic [15:0] got_word, exp_held;
    bit          done = 0;

    always #2.5 clk = ~clk;

    codec_serial_engine u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .host_fs_i(fs), .host_sd_i(sd),
        .host_dc_i(dc), .run_dig_i(run_d), .run_ana_i(run_a), .tx_sample_i(txs),
        .sclk_o(sclk_o), .sd_o(sd_o), .fs_o(fs_o), .drive_en_o(drive_en_o),
        .rx_word_o(rx_word_o), .rx_is_data_o(rx_is_data_o), .rx_stb_o(rx_stb_o),
        .play_word_o(play_word_o), .play_stb_o(play_stb_o)
    );

    always @(negedge clk) begin
        if (rx_stb_o) stb_cnt++;
        if (fs_o)     fs_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // sync: send the host frame sync first; mid: extra sync at bit 5;
    // chain: sync again in the last bit cycle with flag cdc
    task automatic send(input logic [15:0] w, input logic wdc, input bit sync,
                        input bit mid, input bit chain, input logic cdc);
        if (sync) begin
            @(posedge sclk_o); #1; fs = 1'b1; dc = wdc;
        end
        for (int i = 0; i < 16; i++) begin
            @(posedge sclk_o); #1;
            sd = w[15-i];
            fs = (mid && i == 5) || (chain && i == 15);
            dc = (chain && i == 15) ? cdc : wdc;
        end
        @(negedge sclk_o); #1;
        got_stb = rx_stb_o; got_word = rx_word_o; got_dat = rx_is_data_o;
        if (!chain) begin
            @(posedge sclk_o); #1; fs = 1'b0; sd = 1'b0;
        end
    endtask

    task automatic wait_fs(output int n);
        n = 0;
        do begin @(posedge sclk_o); #1; n++; end while (!fs_o && n < 2000);
    endtask

    localparam logic [16:0] VEC [0:4] = '{17'h1_8001, 17'h0_0035, 17'h1_7FFE, 17'h0_8000, 17'h1_1234};

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic s[10];
        int n, c0, f0;
        logic [15:0] tw;
        exp_held = 16'h0;
        repeat (6) @(negedge clk);
        // R11 reset state
        chk(sclk_o == 1'b0, "R11 sclk in reset", sclk_o, 0);
        chk(fs_o == 1'b0 && sd_o == 1'b0, "R11 outputs in reset", {fs_o, sd_o}, 0);
        chk(rx_word_o == 16'h0 && !rx_stb_o, "R11 rx in reset", rx_word_o, 0);
        chk(play_word_o == 16'h0, "R11 play in reset", play_word_o, 0);
        chk(drive_en_o == 1'b1, "R11 drive not gated by reset", drive_en_o, 1);
        @(negedge clk); rst_n = 1'b1;

        // R1 clock pattern
        @(posedge sclk_o);
        for (int k = 0; k < 10; k++) begin @(negedge clk); s[k] = sclk_o; end
        chk({s[0],s[1],s[2],s[3],s[4],s[5],s[6],s[7],s[8],s[9]} == 10'b1100011000,
            "R1 sclk pattern", {s[0],s[1],s[2],s[3],s[4],s[5],s[6],s[7],s[8],s[9]}, 10'b1100011000);

        // R3 R4 vector table
        for (int v = 0; v < 5; v++) begin
            send(VEC[v][15:0], VEC[v][16], 1, 0, 0, 0);
            chk(got_stb == 1'b1, "R3 strobe", got_stb, 1);
            chk(got_word == VEC[v][15:0], "R3 word", got_word, VEC[v][15:0]);
            chk(got_dat == VEC[v][16], "R4 tag", got_dat, VEC[v][16]);
            if (VEC[v][16]) exp_held = VEC[v][15:0];
        end

        // R5 mid-word sync ignored, LSB-cycle sync chains next word
        send(16'hC3A5, 1'b1, 1, 1, 1, 1'b0);
        chk(got_stb && got_word == 16'hC3A5 && got_dat, "R5 first word", got_word, 16'hC3A5);
        exp_held = 16'hC3A5;
        send(16'h0107, 1'b0, 0, 0, 0, 1'b0);
        chk(got_stb && got_word == 16'h0107 && !got_dat, "R5 chained word", {got_dat, got_word}, 17'h0_0107);

        // R2 chip select drop mid-word
        c0 = stb_cnt;
        tw = 16'hDEAD;
        @(posedge sclk_o); #1; fs = 1'b1; dc = 1'b1;
        for (int i = 0; i < 8; i++) begin @(posedge sclk_o); #1; fs = 1'b0; sd = tw[15-i]; end
        @(negedge clk); cs = 1'b0;
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sclk_o || sd_o || fs_o || drive_en_o) n++;
        end
        chk(n == 0, "R2 outputs low with cs low", n, 0);
        // word driven at master-clock pace while deselected
        fs = 1'b1; dc = 1'b1; repeat (5) @(negedge clk); fs = 1'b0;
        for (int i = 0; i < 16; i++) begin sd = i[0]; repeat (5) @(negedge clk); end
        sd = 1'b0; cs = 1'b1;
        repeat (20) @(negedge clk);
        chk(stb_cnt == c0, "R2 no word while deselected", stb_cnt - c0, 0);
        send(16'h4C1D, 1'b1, 1, 0, 0, 1'b0);
        chk(got_stb && got_word == 16'h4C1D, "R2 word after reselect", got_word, 16'h4C1D);
        chk(stb_cnt == c0 + 1, "R2 one strobe only", stb_cnt - c0, 1);
        exp_held = 16'h4C1D;

        // R8 one enable only
        f0 = fs_cnt;
        run_d = 1'b1;
        repeat (2100) @(negedge clk);
        chk(fs_cnt == f0, "R8 no frame with one enable", fs_cnt - f0, 0);

        // R9 wake delay
        txs = 16'hA5C3;
        @(posedge sclk_o); #1; run_a = 1'b1;
        wait_fs(n);
        chk(n == 410, "R9 first frame edge", n, 410);
        // R10 first playback
        @(posedge clk); #1;
        chk(play_stb_o && play_word_o == exp_held, "R10 play at first frame", play_word_o, exp_held);

        // R7 word content; R6 sync width
        tw = 16'h0;
        for (int i = 0; i < 16; i++) begin
            @(posedge sclk_o); #1;
            if (i == 0) begin
                chk(fs_o == 1'b0, "R6 sync one period", fs_o, 0);
                txs = 16'h0F0F;
            end
            tw[15-i] = sd_o;
        end
        chk(tw == 16'hA5C3, "R7 word out", tw, 16'hA5C3);
        wait_fs(n);
        chk(n + 16 == 325, "R6 frame spacing", n + 16, 325);
        tw = 16'h0;
        for (int i = 0; i < 16; i++) begin @(posedge sclk_o); #1; tw[15-i] = sd_o; end
        chk(tw == 16'h0F0F, "R7 sample captured at sync", tw, 16'h0F0F);

        // R10 control word leaves held sample, data word replaces it
        send(16'h0030, 1'b0, 1, 0, 0, 1'b0);
        wait_fs(n);
        @(posedge clk); #1;
        chk(play_stb_o && play_word_o == exp_held, "R10 reuse after control", play_word_o, exp_held);
        send(16'hBEEF, 1'b1, 1, 0, 0, 1'b0);
        wait_fs(n);
        @(posedge clk); #1;
        chk(play_word_o == 16'hBEEF, "R10 new data word", play_word_o, 16'hBEEF);

        // R8 disable stops frames
        @(negedge clk); run_a = 1'b0;
        repeat (3) @(negedge clk);
        f0 = fs_cnt;
        repeat (2000) @(negedge clk);
        chk(fs_cnt == f0 && sd_o == 1'b0, "R8 stop after disable", fs_cnt - f0, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule